// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable model of a synchronous static RAM whose write data trails its command by the same number of cycles as read data. Because of this, a controller can issue read, write and read commands on consecutive clock edges without leaving the data bus idle between them. A parameter selects one of two timings. In registered-output (pipelined) mode, read data leaves an output register. In flow-through mode, the array output goes straight to the pins, and both the read and write paths are one cycle shorter.

Command, address, chip-select, byte-enable and clock-enable inputs are captured on the rising clock edge. Writes are byte-granular on 9-bit bytes. The write address and byte mask wait in a short pipeline until their data arrives. In pipelined mode, a read issued right after a write to the same word returns the new bytes taken from the data-in bus, merged with the old bytes from the array. Burst continuation cycles repeat the type of the last load command at the address presented by an external burst address generator. The data output is a plain bus with a separate drive-enable. An asynchronous output-enable can switch that drive-enable off, and a sleep input freezes the block.

Top module: `sram_zt_core`

## Requirements
- R1: On an active edge with adv low, the command is a read when ce1_n is low, ce2 is high, ce3_n is low and we_n is high. The command is a write when those chip selects hold and we_n is low.
- R2: When PIPELINED=1, read data and rdata_oe appear after the second active edge counted from the command edge. When PIPELINED=0, they appear after the command edge itself. The data stays on the bus until the next active edge.
- R3: When PIPELINED=1, write data is taken from wdata at the second active edge after the write command edge. When PIPELINED=0, it is taken at the first active edge after the command edge.
- R4: be_n bit b is active low and selects wdata bits [9b+8:9b]. Any mix of bytes may be written. A write command with all be_n bits high changes no location.
- R5: A load cycle (adv low) with any chip select inactive is a deselect. It reads and writes nothing, and rdata_oe stays low for the cycle that command would have used.
- R6: A cycle with adv high repeats the operation type of the last load command at the address on addr. It ignores ce1_n, ce2, ce3_n and we_n, takes fresh be_n for writes, and stays a deselect after a deselect load. After reset the last load type is deselect.
- R7: An edge with cke_n high changes no state. A read on the bus keeps the same data driven, and a pending write waits for the next active edge.
- R8: oe_n high forces rdata_oe low without waiting for a clock edge. rdata_oe is low in write and idle cycles, and rdata is zero whenever rdata_oe is low.
- R9: When PIPELINED=1, a read whose address equals that of the write issued one active edge earlier returns that write's enabled bytes from wdata, with the other bytes taken from the array.
- R10: After two consecutive edges with sleep high, the block sleeps: rdata_oe is low, every other input is ignored and the contents are kept. The first edge with sleep low ends the sleep, and the block is active again from the following edge.
- R11: After reset rdata_oe is low and rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control pipeline |
| cke_n | input | 1 | Clock enable, active low; high stalls the edge |
| adv | input | 1 | 0 = load a new command, 1 = continue the last one |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write command when low on a load cycle |
| be_n | input | NBYTES | Byte write enables, active low, one per 9-bit byte |
| addr | input | AW | Word address (from the burst generator on continue cycles) |
| wdata | input | DW | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| rdata | output | DW | Read data, zero when not driven |
| rdata_oe | output | 1 | Drive enable for rdata |

## Verification
The assertions take for granted that every input except oe_n is stable around the rising edge. They also take for granted that sleep is raised only after the pipeline has drained, and that the first command after a wake is a deselect or a read. The stimulus meets these conditions in three ways. It changes inputs only on the falling edge. It issues three deselect loads before raising sleep. After sleep falls, it sends only deselects and reads. Reads are issued only to words that have already been written in full, so no check ever depends on uninitialised array contents.

// File: rtl/sram_zt_pkg.sv
package sram_zt_pkg;
    localparam int BYTE_W = 9;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/sram_zt_decode.sv
module sram_zt_decode
    import sram_zt_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic              adv,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              we_n,
    input  logic [NBYTES-1:0] be_n,
    input  op_e               last_op,
    output op_e               op,
    output logic [NBYTES-1:0] mask,
    output op_e               next_last
);
    logic selected;
    op_e  kind;

    assign selected = !ce1_n && ce2 && !ce3_n;

    always_comb begin
        if (!adv) begin
            if (!selected)  kind = OP_IDLE;
            else if (we_n)  kind = OP_READ;
            else            kind = OP_WRITE;
            next_last = kind;
        end else begin
            kind      = last_op;
            next_last = last_op;
        end
        mask = (kind == OP_WRITE) ? ~be_n : '0;
        // a write with no byte selected does nothing
        op   = (kind == OP_WRITE && mask == '0) ? OP_IDLE : kind;
    end
endmodule

// File: rtl/sram_zt_array.sv
module sram_zt_array
    import sram_zt_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int NBYTES = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [NBYTES-1:0] wr_mask,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b]) begin
                lane[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
            end
        end

        assign rd_data[b*BYTE_W +: BYTE_W] = lane[rd_addr];
    end
endmodule

// File: rtl/sram_zt_merge.sv
module sram_zt_merge
    import sram_zt_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int DW    = NBYTES * BYTE_W
) (
    input  logic              hit,
    input  logic [NBYTES-1:0] mask,
    input  logic [DW-1:0]     base,
    input  logic [DW-1:0]     fwd,
    output logic [DW-1:0]     merged
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign merged[b*BYTE_W +: BYTE_W] = (hit && mask[b]) ?
            fwd[b*BYTE_W +: BYTE_W] : base[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/sram_zt_core.sv
module sram_zt_core
    import sram_zt_pkg::*;
#(
    parameter bit PIPELINED = 1'b1,
    parameter int DEPTH     = 64,
    parameter int NBYTES    = 4,
    localparam int AW       = $clog2(DEPTH),
    localparam int DW       = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              adv,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              we_n,
    input  logic [NBYTES-1:0] be_n,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DW-1:0]     rdata,
    output logic              rdata_oe
);
    localparam logic [1:0] SLEEP_AFTER = 2'd2;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [AW-1:0]     addr;
        logic [NBYTES-1:0] mask;
    } stage_t;

    typedef struct packed {
        stage_t        s1;     // command captured at the last active edge
        stage_t        s2;     // write waiting for its data (pipelined only)
        op_e           last;   // type of the last load command
        logic [DW-1:0] dout;   // output register (pipelined only)
        logic          dvld;
        logic [1:0]    slp;    // edges seen with sleep high
    } state_t;

    state_t state_d, state_q;

    logic              asleep;
    logic              active;
    op_e               dec_op;
    op_e               dec_last;
    logic [NBYTES-1:0] dec_mask;
    stage_t            commit;
    logic [DW-1:0]     arr_word;
    logic [DW-1:0]     fwd_word;
    logic              fwd_hit;
    logic [DW-1:0]     drv_data;
    logic              drv_vld;

    assign asleep = (state_q.slp == SLEEP_AFTER);
    assign active = !cke_n && !asleep;

    sram_zt_decode #(.NBYTES(NBYTES)) u_decode (
        .adv       (adv),
        .ce1_n     (ce1_n),
        .ce2       (ce2),
        .ce3_n     (ce3_n),
        .we_n      (we_n),
        .be_n      (be_n),
        .last_op   (state_q.last),
        .op        (dec_op),
        .mask      (dec_mask),
        .next_last (dec_last)
    );

    if (PIPELINED) begin : g_pipe
        assign commit   = state_q.s2;
        assign fwd_hit  = state_q.s2.wr && (state_q.s2.addr == state_q.s1.addr);
        assign drv_data = state_q.dout;
        assign drv_vld  = state_q.dvld;
    end else begin : g_flow
        assign commit   = state_q.s1;
        assign fwd_hit  = 1'b0;
        assign drv_data = arr_word;
        assign drv_vld  = state_q.s1.rd;
    end

    sram_zt_array #(.DEPTH(DEPTH), .NBYTES(NBYTES)) u_array (
        .clk     (clk),
        .wr_en   (active && commit.wr),
        .wr_addr (commit.addr),
        .wr_mask (commit.mask),
        .wr_data (wdata),
        .rd_addr (state_q.s1.addr),
        .rd_data (arr_word)
    );

    sram_zt_merge #(.NBYTES(NBYTES)) u_merge (
        .hit    (fwd_hit),
        .mask   (state_q.s2.mask),
        .base   (arr_word),
        .fwd    (wdata),
        .merged (fwd_word)
    );

    always_comb begin
        state_d = state_q;
        if (active) begin
            state_d.s1.rd   = (dec_op == OP_READ);
            state_d.s1.wr   = (dec_op == OP_WRITE);
            state_d.s1.addr = addr;
            state_d.s1.mask = dec_mask;
            state_d.s2      = state_q.s1;
            state_d.s2.rd   = 1'b0;
            state_d.last    = dec_last;
            state_d.dvld    = state_q.s1.rd;
            if (state_q.s1.rd) begin
                state_d.dout = fwd_word;
            end
        end
        if (!sleep)                        state_d.slp = '0;
        else if (state_q.slp != SLEEP_AFTER) state_d.slp = state_q.slp + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.last <= OP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_oe = drv_vld && !oe_n && !asleep;
    assign rdata    = rdata_oe ? drv_data : '0;
endmodule

// File: rtl/sram_zt_checker.sv
module sram_zt_checker #(
    parameter bit PIPELINED = 1'b1,
    parameter int DW        = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke_n,
    input logic          adv,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3_n,
    input logic          we_n,
    input logic          oe_n,
    input logic          sleep,
    input logic          slept,
    input logic          rdata_oe,
    input logic [DW-1:0] rdata
);
    logic act, sel, ld_rd, ld_wr, ld_off;

    assign act    = !cke_n && !slept;
    assign sel    = !ce1_n && ce2 && !ce3_n;
    assign ld_rd  = act && !adv && sel && we_n;
    assign ld_wr  = act && !adv && sel && !we_n;
    assign ld_off = act && !adv && !sel;

    AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_oe); // R8
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0)); // R8
    AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        slept |-> !rdata_oe); // R10
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_n && !sleep && !$past(sleep) && !oe_n)
        |=> (oe_n || ($stable(rdata_oe) && $stable(rdata)))); // R7

    if (PIPELINED) begin : g_pipe
        AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            ld_off ##1 act |=> !rdata_oe); // R5
        AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
            ld_rd ##1 (act && !sleep) |=> (oe_n || rdata_oe)); // R2
    end else begin : g_flow
        AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            ld_off |=> !rdata_oe); // R5
        AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            ld_wr |=> !rdata_oe); // R8
        AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_rd && !sleep) |=> (oe_n || rdata_oe)); // R2
    end
endmodule

bind sram_zt_core sram_zt_checker #(.PIPELINED(PIPELINED), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke_n    (cke_n),
    .adv      (adv),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .slept    (asleep),
    .rdata_oe (rdata_oe),
    .rdata    (rdata)
);

// File: tb/sram_zt_core_test.sv
module sram_zt_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int NB         = 4;
    localparam int AW         = 6;
    localparam int DW         = NB * 9;
    localparam int WATCHDOG   = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic          adv = 1'b0;
    logic          ce1_n = 1'b1;
    logic          ce2 = 1'b1;
    logic          ce3_n = 1'b0;
    logic          we_n = 1'b1;
    logic [NB-1:0] be_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [DW-1:0] rd_p, rd_f;
    logic          oe_p, oe_f;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R11";
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_zt_core #(.PIPELINED(1'b1), .DEPTH(DEPTH), .NBYTES(NB)) uut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .ce1_n(ce1_n),
        .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .be_n(be_n), .addr(addr),
        .wdata(wdata), .oe_n(oe_n), .sleep(sleep), .rdata(rd_p), .rdata_oe(oe_p)
    );

    sram_zt_core #(.PIPELINED(1'b0), .DEPTH(DEPTH), .NBYTES(NB)) uut_ft (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .ce1_n(ce1_n),
        .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .be_n(be_n), .addr(addr),
        .wdata(wdata), .oe_n(oe_n), .sleep(sleep), .rdata(rd_f), .rdata_oe(oe_f)
    );

    // ---------------- behavioural reference ----------------
    typedef struct {
        int            due;
        int            a;
        logic [NB-1:0] mask;
    } pend_t;

    logic [DW-1:0] mem_f [DEPTH];
    logic [DW-1:0] mem_p [DEPTH];
    pend_t         pq_f[$];
    pend_t         pq_p[$];
    int            n_act, m_last, m_slp, prd_a;
    bit            m_asleep, prd_v, ev_f, ev_p;
    logic [DW-1:0] ed_f, ed_p;

    function automatic logic [DW-1:0] put(logic [DW-1:0] old, logic [DW-1:0] d,
                                          logic [NB-1:0] m);
        logic [DW-1:0] r = old;
        for (int b = 0; b < NB; b++) if (m[b]) r[b*9 +: 9] = d[b*9 +: 9];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            n_act = 0; m_last = 0; m_slp = 0; m_asleep = 0;
            prd_v = 0; prd_a = 0; ev_f = 0; ev_p = 0;
            pq_f.delete(); pq_p.delete();
        end else begin
            if (!cke_n && !m_asleep) begin
                int mop;
                pend_t e;
                n_act++;
                if (pq_f.size() > 0 && pq_f[0].due == n_act) begin
                    mem_f[pq_f[0].a] = put(mem_f[pq_f[0].a], wdata, pq_f[0].mask);
                    pq_f.delete(0);
                end
                if (pq_p.size() > 0 && pq_p[0].due == n_act) begin
                    mem_p[pq_p[0].a] = put(mem_p[pq_p[0].a], wdata, pq_p[0].mask);
                    pq_p.delete(0);
                end
                if (!adv) begin
                    if (ce1_n || !ce2 || ce3_n) mop = 0;
                    else if (we_n)              mop = 1;
                    else                        mop = 2;
                    m_last = mop;
                end else begin
                    mop = m_last;
                end
                ev_f = (mop == 1);
                ed_f = mem_f[addr];
                ev_p = prd_v;
                ed_p = mem_p[prd_a];
                prd_v = (mop == 1);
                prd_a = int'(addr);
                if (mop == 2 && be_n != '1) begin
                    e.a = int'(addr); e.mask = ~be_n;
                    e.due = n_act + 1; pq_f.push_back(e);
                    e.due = n_act + 2; pq_p.push_back(e);
                end
            end
            if (sleep) begin
                if (m_slp < 2) m_slp++;
            end else begin
                m_slp = 0;
            end
            m_asleep = (m_slp == 2);
        end
    end

    task automatic check(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (!done) begin
            bit xo_f, xo_p;
            xo_f = ev_f && !oe_n && !m_asleep;
            xo_p = ev_p && !oe_n && !m_asleep;
            check(oe_f == xo_f, "flow drive", DW'(oe_f), DW'(xo_f));
            check(oe_p == xo_p, "pipe drive", DW'(oe_p), DW'(xo_p));
            check(rd_f == (xo_f ? ed_f : '0), "flow data", rd_f, xo_f ? ed_f : '0);
            check(rd_p == (xo_p ? ed_p : '0), "pipe data", rd_p, xo_p ? ed_p : '0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        wdata = DW'({$urandom, $urandom});
        @(negedge clk);
    endtask

    task automatic load(int kind, int a, logic [NB-1:0] be);
        cke_n = 1'b0; adv = 1'b0; ce1_n = (kind == 0); ce2 = 1'b1; ce3_n = 1'b0;
        we_n = (kind != 2); be_n = be; addr = AW'(a);
        step();
    endtask

    task automatic desel(int which);
        cke_n = 1'b0; adv = 1'b0; ce1_n = (which == 0); ce2 = (which != 1);
        ce3_n = (which == 2); we_n = which[0]; addr = AW'(which);
        step();
    endtask

    task automatic cont(int a, logic [NB-1:0] be);
        cke_n = 1'b0; adv = 1'b1; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
        we_n = ~we_n; be_n = be; addr = AW'(a);
        step();
    endtask

    task automatic stall(int n);
        cke_n = 1'b1; adv = 1'b0; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        we_n = 1'b0; be_n = '0; addr = AW'(40);
        repeat (n) step();
        cke_n = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) load(0, 0, '1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R3";              // fill every word used later
        for (int i = 0; i < 32; i++) load(2, i, '0);
        idle(3);

        cur_req = "R1 R2";           // back-to-back reads
        for (int i = 0; i < 32; i++) load(1, i, '1);
        idle(3);

        cur_req = "R4";              // each byte alone, pairs, and an abort
        load(2, 3, 4'b1110); load(2, 4, 4'b1101); load(2, 5, 4'b1011);
        load(2, 6, 4'b0111); load(2, 7, 4'b1010); load(2, 8, 4'b1111);
        idle(2);
        for (int i = 3; i < 9; i++) load(1, i, '1);
        idle(3);

        cur_req = "R9";              // read straight after a write to the same word
        load(2, 10, 4'b0110); load(1, 10, '1);
        load(2, 11, 4'b1001); load(2, 11, 4'b1100); load(1, 11, '1);
        load(1, 10, '1); load(2, 12, 4'b0000); load(1, 12, '1);
        for (int i = 0; i < 80; i++) begin
            int k = $urandom_range(0, 3);
            int a = $urandom_range(10, 13);
            if (k == 0)      load(2, a, NB'($urandom));
            else if (k == 1) load(1, a, '1);
            else if (k == 2) cont(a, NB'($urandom));
            else             desel($urandom_range(0, 2));
        end
        idle(3);

        cur_req = "R5";              // each chip select alone deselects
        load(1, 1, '1); desel(0); load(1, 2, '1); desel(1);
        load(1, 3, '1); desel(2); desel(0); load(1, 4, '1);
        idle(3);

        cur_req = "R6";              // continues follow the last load type
        load(1, 20, '1); cont(21, '1); cont(22, '1);
        load(2, 23, 4'b1100); cont(24, 4'b0101); cont(25, 4'b1111);
        desel(1); cont(26, 4'b0000); cont(27, 4'b0000);
        idle(2);
        for (int i = 20; i < 28; i++) load(1, i, '1);
        idle(3);

        cur_req = "R7";              // stalls hold reads and delay write data
        load(1, 14, '1); stall(3); load(1, 15, '1); stall(2); idle(1); stall(2);
        load(2, 16, 4'b0000); stall(2); load(2, 17, 4'b0011); stall(1);
        idle(1); stall(2); idle(2);
        load(1, 16, '1); load(1, 17, '1);
        idle(3);

        cur_req = "R8";              // output enable forces the bus off
        load(1, 1, '1); oe_n = 1'b1; load(1, 2, '1); load(1, 3, '1);
        oe_n = 1'b0; load(1, 4, '1); oe_n = 1'b1; idle(1); oe_n = 1'b0;
        load(2, 5, '0); load(2, 6, '0); idle(3);

        cur_req = "R10";             // sleep freezes everything and keeps contents
        idle(3);
        sleep = 1'b1;
        idle(2);
        for (int i = 0; i < 8; i++) load(2, i, '0);
        for (int i = 0; i < 4; i++) load(1, i, '1);
        sleep = 1'b0;
        idle(2);
        for (int i = 0; i < 32; i++) load(1, i, '1);
        idle(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL %s watchdog: actual %0d expected %0d", cur_req, WATCHDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule